// File: doc/BRIEF.md
# Voice Control Command Sequencer

This block executes one decoded control command per cycle strobe and keeps the ten 8-bit registers that steer voice playback: four general registers and six control registers. The registers hold the trigger edge enables, the LED and pin configuration, the stop pin levels and the page select. A separate fetch stage delivers the commands already split into fields: opcode, destination index, general source index, immediate byte, jump source select, condition select and trigger select. The command set is load, jump, move, increment and end. Any of them can be made conditional on the last-play flag or on the level of one chosen trigger pin.

A jump does not change the registers. It raises a one-cycle request and presents a target vector, taken from the immediate or from a general register, to the fetch stage. An end command raises an idle flag, which stays up until another command executes. Bits that carry no meaning are never stored, so they always read back as 0. The page register also keeps only the bits that the static page-mode input allows.

Top module: `cmdseq_top`

## Requirements
- R1: After reset R0..R3 read 0x20, EN0 and EN1 read 0x33, MODE0 reads 0xD4, MODE1 reads 0x3C, STOP reads 0x1F, PAGE reads 0x00, end_o is 1, jump_o is 0 and vec_o is 0x00.
- R2: Load (op 0) writes imm_i to the register selected by dst_i. The indices are 0..3 for R0..R3, 4 for EN0, 5 for EN1, 6 for MODE0, 7 for MODE1, 8 for STOP and 9 for PAGE. A control register stores only its kept bits: mask 0x33 for EN0/EN1, 0xD4 for MODE0, 0x3C for MODE1 and 0x1F for STOP. All other bits read 0. A load to an index from 10 to 15 changes no register.
- R3: A load to PAGE also masks the value by page_mode_i: 0 gives mask 0x00, 1 gives 0x07, 2 gives 0x0F and 3 gives 0x1F.
- R4: Increment (op 3) adds 1 to R0 modulo 256, so 0xFF becomes 0x00. It leaves R1..R3 unchanged.
- R5: Move (op 2) copies the general register selected by src_i into the general register selected by dst_i[1:0]. The source is not changed.
- R6: Jump (op 1) raises jump_o for exactly the one cycle that follows the executing strobe. The same edge loads vec_o with imm_i when jp_reg_i is 0, or with the general register selected by src_i when jp_reg_i is 1. vec_o holds that value until the next jump.
- R7: End (op 4) sets end_o. An executed load, jump, move or increment clears end_o. Opcodes 5..7 have no effect on any output.
- R8: cond_i selects the condition: 0 always, 1 last_i high, 2 trigger trig_i[trig_sel_i] high, 3 that trigger low. When the condition is false, the command changes no register, jump_o, vec_o or end_o.
- R9: Without step_i no command executes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Cycle strobe; executes the presented command |
| op_i | input | 3 | Opcode: 0 load, 1 jump, 2 move, 3 increment, 4 end |
| dst_i | input | 4 | Destination register index |
| src_i | input | 2 | General source register for move or register jump |
| imm_i | input | 8 | Immediate value or jump vector |
| jp_reg_i | input | 1 | Jump target from the general register selected by src_i |
| cond_i | input | 2 | Condition select |
| trig_sel_i | input | 2 | Trigger pin tested by the condition |
| trig_i | input | 4 | Trigger pin levels |
| last_i | input | 1 | Last-play flag |
| page_mode_i | input | 2 | Static page mode: 1, 8, 16 or 32 pages |
| r0_o | output | 8 | General register R0 |
| r1_o | output | 8 | General register R1 |
| r2_o | output | 8 | General register R2 |
| r3_o | output | 8 | General register R3 |
| en0_o | output | 8 | Edge enables, first pin pair |
| en1_o | output | 8 | Edge enables, second pin pair |
| mode0_o | output | 8 | Mode register 0 |
| mode1_o | output | 8 | Mode register 1 |
| stop_o | output | 8 | Stop pin levels, bits 0..4 |
| page_o | output | 8 | Page select |
| jump_o | output | 1 | One-cycle jump request |
| vec_o | output | 8 | Jump target vector |
| end_o | output | 1 | Idle flag after an end command |

## Verification
Directed commands first write all ones into each control register and each page mode, so that the mask on every register is seen in isolation. They then cover the R0 wrap at 0xFF and loads to the unused indices. Every condition type is run both true and false, which shows whether the gating reaches each effect: registers, jump and idle flag. A held command without a strobe separates execution from mere input presence. Seeded random streams then mix all opcodes, conditions, trigger levels and page modes, and compare every output after each command against a bench model. This shows up ordering errors, such as a move reading a stale value or a register jump reading the wrong source.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int REG_W  = 8;
  localparam int N_GPR  = 4;
  localparam int N_SPR  = 6;
  localparam int IDX_W  = 4;

  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_JP  = 3'd1;
  localparam logic [2:0] OP_MV  = 3'd2;
  localparam logic [2:0] OP_INC = 3'd3;
  localparam logic [2:0] OP_END = 3'd4;

  localparam logic [1:0] C_ALWAYS = 2'd0;
  localparam logic [1:0] C_LAST   = 2'd1;
  localparam logic [1:0] C_TRG_HI = 2'd2;
  localparam logic [1:0] C_TRG_LO = 2'd3;

  // kept-bit mask per control register, k = 0..5 -> EN0, EN1, MODE0, MODE1, STOP, PAGE
  function automatic logic [REG_W-1:0] spr_keep(input int k);
    case (k)
      0, 1:    return 8'h33;
      2:       return 8'hD4;
      3:       return 8'h3C;
      4, 5:    return 8'h1F;
      default: return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] spr_rst(input int k);
    return (k == 5) ? '0 : spr_keep(k);
  endfunction

  function automatic logic [REG_W-1:0] page_keep(input logic [1:0] mode);
    case (mode)
      2'd1:    return 8'h07;
      2'd2:    return 8'h0F;
      2'd3:    return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cmdseq_cond.sv
module cmdseq_cond #(
  parameter int N_TRIG = 4,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic [1:0]        cond_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              last_i,
  output logic              fire_o
);
  import cmdseq_pkg::*;

  logic lvl;
  assign lvl = trig_i[sel_i];

  always_comb begin
    case (cond_i)
      C_LAST:   fire_o = last_i;
      C_TRG_HI: fire_o = lvl;
      C_TRG_LO: fire_o = ~lvl;
      default:  fire_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmdseq_gpr.sv
module cmdseq_gpr #(
  parameter int W = 8,
  parameter int N = 4,
  parameter logic [W-1:0] RST_VAL = 8'h20,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [IW-1:0]     ld_idx_i,
  input  logic [W-1:0]      ld_val_i,
  input  logic              mv_en_i,
  input  logic [IW-1:0]     mv_dst_i,
  input  logic [IW-1:0]     mv_src_i,
  input  logic              inc_en_i,
  output logic [N-1:0][W-1:0] r_o
);
  logic [N-1:0][W-1:0] r_q;
  logic [W-1:0] mv_val;
  assign mv_val = r_q[mv_src_i];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               r_q[g] <= RST_VAL;
      else if (ld_en_i && ld_idx_i == IW'(g))    r_q[g] <= ld_val_i;
      else if (mv_en_i && mv_dst_i == IW'(g))    r_q[g] <= mv_val;
      else if (inc_en_i && g == 0)               r_q[g] <= r_q[g] + W'(1);
    end
  end

  assign r_o = r_q;

  // R4: increment touches R0 only
  p_inc_r0_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_en_i && !ld_en_i && !mv_en_i) |=> ($stable(r_q[N-1:1]) && r_q[0] == $past(r_q[0]) + W'(1)));
  // R5: move copies source value
  p_mv_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_en_i && !ld_en_i) |=> r_q[$past(mv_dst_i)] == $past(r_q[mv_src_i]));
endmodule

// File: rtl/cmdseq_spr.sv
module cmdseq_spr #(
  parameter int W = 8,
  parameter int N = 6,
  parameter int IW = 4,
  parameter int BASE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [IW-1:0]     ld_idx_i,
  input  logic [W-1:0]      ld_val_i,
  input  logic [1:0]        page_mode_i,
  output logic [N-1:0][W-1:0] s_o
);
  import cmdseq_pkg::*;

  logic [N-1:0][W-1:0] s_q;
  logic [W-1:0] pmask;
  assign pmask = page_keep(page_mode_i);

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [W-1:0] KEEP = spr_keep(g);
    localparam logic [W-1:0] RSTV = spr_rst(g);
    logic [W-1:0] wval;
    if (g == N - 1) begin : g_page
      assign wval = ld_val_i & KEEP & pmask;
    end else begin : g_plain
      assign wval = ld_val_i & KEEP;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   s_q[g] <= RSTV;
      else if (ld_en_i && ld_idx_i == IW'(BASE + g)) s_q[g] <= wval;
    end
  end

  assign s_o = s_q;

  // R3: page load honours page mode
  p_page_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && ld_idx_i == IW'(BASE + N - 1)) |=> (s_q[N-1] & ~page_keep($past(page_mode_i))) == '0);
  // R2: writes hit only the addressed register
  p_single_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en_i |=> $stable(s_q));
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [2:0] op_i,
  input  logic [3:0] dst_i,
  input  logic [1:0] src_i,
  input  logic [7:0] imm_i,
  input  logic       jp_reg_i,
  input  logic [1:0] cond_i,
  input  logic [1:0] trig_sel_i,
  input  logic [3:0] trig_i,
  input  logic       last_i,
  input  logic [1:0] page_mode_i,
  output logic [7:0] r0_o,
  output logic [7:0] r1_o,
  output logic [7:0] r2_o,
  output logic [7:0] r3_o,
  output logic [7:0] en0_o,
  output logic [7:0] en1_o,
  output logic [7:0] mode0_o,
  output logic [7:0] mode1_o,
  output logic [7:0] stop_o,
  output logic [7:0] page_o,
  output logic       jump_o,
  output logic [7:0] vec_o,
  output logic       end_o
);
  localparam int GIW = $clog2(N_GPR);
  localparam int TOP_IDX = N_GPR + N_SPR - 1;

  logic fire, exec;
  logic [N_GPR-1:0][REG_W-1:0] gpr;
  logic [N_SPR-1:0][REG_W-1:0] spr;

  cmdseq_cond #(.N_TRIG(4)) u_cond (
    .cond_i(cond_i), .sel_i(trig_sel_i), .trig_i(trig_i),
    .last_i(last_i), .fire_o(fire)
  );

  assign exec = step_i & fire;

  logic is_ld, is_jp, is_mv, is_inc, is_end, ld_gpr, ld_spr;
  assign is_ld  = exec && op_i == OP_LD;
  assign is_jp  = exec && op_i == OP_JP;
  assign is_mv  = exec && op_i == OP_MV;
  assign is_inc = exec && op_i == OP_INC;
  assign is_end = exec && op_i == OP_END;
  assign ld_gpr = is_ld && dst_i < IDX_W'(N_GPR);
  assign ld_spr = is_ld && dst_i >= IDX_W'(N_GPR) && dst_i <= IDX_W'(TOP_IDX);

  cmdseq_gpr #(.W(REG_W), .N(N_GPR), .RST_VAL(8'h20)) u_gpr (
    .clk_i, .rst_ni,
    .ld_en_i(ld_gpr), .ld_idx_i(dst_i[GIW-1:0]), .ld_val_i(imm_i),
    .mv_en_i(is_mv), .mv_dst_i(dst_i[GIW-1:0]), .mv_src_i(src_i),
    .inc_en_i(is_inc), .r_o(gpr)
  );

  cmdseq_spr #(.W(REG_W), .N(N_SPR), .IW(IDX_W), .BASE(N_GPR)) u_spr (
    .clk_i, .rst_ni,
    .ld_en_i(ld_spr), .ld_idx_i(dst_i), .ld_val_i(imm_i),
    .page_mode_i(page_mode_i), .s_o(spr)
  );

  logic       jump_q, end_q;
  logic [7:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jump_q <= 1'b0;
      vec_q  <= '0;
      end_q  <= 1'b1;
    end else begin
      jump_q <= is_jp;
      if (is_jp) vec_q <= jp_reg_i ? gpr[src_i] : imm_i;
      if (is_end) end_q <= 1'b1;
      else if (is_ld || is_jp || is_mv || is_inc) end_q <= 1'b0;
    end
  end

  assign {r3_o, r2_o, r1_o, r0_o} = gpr;
  assign {page_o, stop_o, mode1_o, mode0_o, en1_o, en0_o} = spr;
  assign jump_o = jump_q;
  assign vec_o  = vec_q;
  assign end_o  = end_q;

  // R6: jump request is a single-cycle pulse
  p_jump_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !jump_o);
  // R7: end raises idle flag
  p_end_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && fire && op_i == OP_END) |=> end_o);
  // R8/R9: no execution leaves all state unchanged
  p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && fire) |=> ($stable(gpr) && $stable(spr) && $stable(vec_o) && $stable(end_o) && !jump_o));
  // R4: R0 wraps
  p_inc_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && fire && op_i == OP_INC && r0_o == 8'hFF) |=> r0_o == 8'h00);
endmodule

// File: tb/cmdseq_top_tb.sv
module cmdseq_top_tb;
  logic clk = 0, rst_ni = 0;
  logic step = 0, jpr = 0, last = 0;
  logic [2:0] op = 0;
  logic [3:0] dst = 0, trig = 0;
  logic [1:0] src = 0, cond = 0, tsel = 0, pmode = 0;
  logic [7:0] imm = 0;
  logic [7:0] r0, r1, r2, r3, en0, en1, md0, md1, stp, pg, vec;
  logic jump, endf;

  always #10 clk = ~clk;

  cmdseq_top u_dut (
    .clk_i(clk), .rst_ni, .step_i(step), .op_i(op), .dst_i(dst), .src_i(src),
    .imm_i(imm), .jp_reg_i(jpr), .cond_i(cond), .trig_sel_i(tsel), .trig_i(trig),
    .last_i(last), .page_mode_i(pmode),
    .r0_o(r0), .r1_o(r1), .r2_o(r2), .r3_o(r3), .en0_o(en0), .en1_o(en1),
    .mode0_o(md0), .mode1_o(md1), .stop_o(stp), .page_o(pg),
    .jump_o(jump), .vec_o(vec), .end_o(endf)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m [10];
  logic [7:0] mvec;
  logic mjmp, mend;

  function automatic logic [7:0] keep(int i);
    case (i)
      0, 1, 2, 3: return 8'hFF;
      4, 5: return 8'h33;
      6: return 8'hD4;
      7: return 8'h3C;
      8, 9: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pkeep(logic [1:0] pm);
    case (pm) 2'd1: return 8'h07; 2'd2: return 8'h0F; 2'd3: return 8'h1F; default: return 8'h00; endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m[i] = 8'h20;
    m[4] = 8'h33; m[5] = 8'h33; m[6] = 8'hD4; m[7] = 8'h3C; m[8] = 8'h1F; m[9] = 8'h00;
    mvec = 0; mjmp = 0; mend = 1;
  endtask

  task automatic compare(string tag);
    logic [79:0] a, e;
    logic [9:0] a2, e2;
    a = {r0, r1, r2, r3, en0, en1, md0, md1, stp, pg};
    e = {m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7], m[8], m[9]};
    a2 = {jump, endf, vec};
    e2 = {mjmp, mend, mvec};
    n_chk++;
    if (a !== e || a2 !== e2) begin
      n_bad++;
      $display("FAIL %s: act regs=%h ctl=%h exp regs=%h ctl=%h", tag, a, a2, e, e2);
    end
  endtask

  // called at a negedge; executes one cycle and checks at the next negedge
  task automatic run(bit stb, logic [2:0] o, logic [3:0] d, logic [1:0] s, logic [7:0] im,
                     bit jr, logic [1:0] c, logic [1:0] ts, logic [3:0] tg, bit ls, string tag);
    bit f;
    step = stb; op = o; dst = d; src = s; imm = im; jpr = jr; cond = c; tsel = ts; trig = tg; last = ls;
    f = (c == 0) || (c == 1 && ls) || (c == 2 && tg[ts]) || (c == 3 && !tg[ts]);
    mjmp = 0;
    if (stb && f) begin
      case (o)
        3'd0: begin
          if (d <= 9) m[d] = im & keep(d) & ((d == 9) ? pkeep(pmode) : 8'hFF);
          mend = 0;
        end
        3'd1: begin mjmp = 1; mvec = jr ? m[s] : im; mend = 0; end
        3'd2: begin m[d[1:0]] = m[s]; mend = 0; end
        3'd3: begin m[0] = m[0] + 8'd1; mend = 0; end
        3'd4: mend = 1;
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    step = 0;
    compare(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1;
    @(negedge clk);
    compare("R1 after reset");

    pmode = 2'd3;
    for (int i = 4; i <= 9; i++) run(1, 0, i[3:0], 0, 8'hFF, 0, 0, 0, 0, 0, "R2 masked load");
    for (int i = 0; i <= 9; i++) run(1, 0, i[3:0], 0, 8'h00, 0, 0, 0, 0, 0, "R2 clear load");
    run(1, 0, 4'd12, 0, 8'hAA, 0, 0, 0, 0, 0, "R2 unused index");
    for (int p = 0; p < 4; p++) begin
      pmode = p[1:0];
      run(1, 0, 4'd9, 0, 8'hFF, 0, 0, 0, 0, 0, "R3 page mode");
    end
    run(1, 0, 4'd0, 0, 8'hFF, 0, 0, 0, 0, 0, "R2 load R0");
    run(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 wrap");
    run(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 increment");
    run(1, 0, 4'd2, 0, 8'h5C, 0, 0, 0, 0, 0, "R2 load R2");
    run(1, 2, 4'd3, 2'd2, 0, 0, 0, 0, 0, 0, "R5 move");
    run(1, 1, 0, 0, 8'h91, 0, 0, 0, 0, 0, "R6 jump imm");
    run(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 pulse ends");
    run(1, 1, 0, 2'd3, 8'h00, 1, 0, 0, 0, 0, "R6 jump reg");
    run(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R7 end");
    run(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, "R7 unused opcode");
    run(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R7 end cleared");
    run(1, 4, 0, 0, 0, 0, 1, 0, 0, 0, "R8 last false");
    run(1, 4, 0, 0, 0, 0, 1, 0, 0, 1, "R8 last true");
    run(1, 1, 0, 0, 8'h33, 0, 2, 2'd1, 4'b1101, 0, "R8 trig high false");
    run(1, 1, 0, 0, 8'h34, 0, 2, 2'd2, 4'b0100, 0, "R8 trig high true");
    run(1, 0, 4'd1, 0, 8'h77, 0, 3, 2'd3, 4'b1000, 0, "R8 trig low false");
    run(1, 0, 4'd1, 0, 8'h78, 0, 3, 2'd0, 4'b1110, 0, "R8 trig low true");
    run(0, 0, 4'd1, 0, 8'h99, 0, 0, 0, 0, 0, "R9 no strobe");
    run(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R9 no strobe inc");

    for (int k = 0; k < 600; k++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 5));
      if (k % 50 == 0) pmode = 2'($urandom);
      run(($urandom % 8) != 0, o, 4'($urandom_range(0, 11)), 2'($urandom), 8'($urandom),
          1'($urandom), 2'($urandom), 2'($urandom), 4'($urandom), 1'($urandom),
          (o == 0) ? "R2 random load" : (o == 1) ? "R6 random jump" : (o == 2) ? "R5 random move" :
          (o == 3) ? "R4 random inc" : "R7 random end");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule